// File: doc/BRIEF.md
# Parallel Flash Write and Erase Sequencer

This block sits on the host side of a byte-wide parallel flash device. It turns one request into the complete bus activity needed to change the flash contents: a byte write, the erase of a sector, the erase of a block, or the erase of the whole chip. For each request it issues the protected command sequence as a run of write strobes. It then polls the device with read cycles until the device reports that its internal operation has ended. Last, it reads back the target byte and returns a done pulse together with an error flag.

Every bus interval is a whole number of clock cycles. The setup of each write cycle, the width of the write strobe, the data hold, and the length of a read cycle are all parameters. Completion can be detected in two ways, chosen per request. Bit 7 polling waits for the top data bit to show its final value. Toggle detection waits until bit 6 returns the same value on two reads in a row. A read that lands just as the device finishes can show a misleading value. The sequencer therefore treats a failed read-back as a possible race and reads the location twice more before it reports an error. A timeout bounds the polling phase. Its length comes from the clock rate, a program limit in microseconds, and a scale factor for erases.

The flash data pins are split into an output byte, an output enable and an input byte, which the pad ring combines into one tri-state bus.

Top module: `flash_wr_engine`

## Requirements
- R1: A byte write (req_op 0) issues exactly four write cycles, as address/data pairs: 5555h/AAh, 2AAAh/55h, 5555h/A0h, then req_addr/req_data.
- R2: A sector erase (req_op 1) issues exactly six write cycles: 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, then req_addr/30h.
- R3: A block erase (req_op 2) issues the same first five cycles as R2 and ends with req_addr/50h.
- R4: A chip erase (req_op 3) issues the same first five cycles as R2 and ends with 5555h/10h.
- R5: In each write cycle the address is valid and chip enable is low before write enable falls. Address and data stay driven and unchanged up to and including the cycle in which write enable rises. Write enable and output enable are never low together.
- R6: Every read cycle drives chip enable and output enable low, and the host stops driving the data pins whenever output enable is low.
- R7: With poll_toggle at 0, polling ends on the first status read whose bit 7 equals bit 7 of the expected byte. The expected byte is req_data for a byte write and FFh for any erase.
- R8: With poll_toggle at 1, polling ends on the first status read whose bit 6 equals bit 6 of the previous status read of the same request.
- R9: Once polling ends, one read of req_addr is compared with the expected byte. On a match the request completes without error. On a mismatch two more reads follow, and the request fails only if either of them differs from the expected byte.
- R10: No read cycle of a request starts before the last write cycle of its sequence has ended.
- R11: If polling has not ended within CLK_MHZ*PROG_LIMIT_US cycles for a byte write, or ERASE_SCALE times that for an erase, the request completes with error high.
- R12: A request is taken only while busy is low. busy stays high from the cycle after acceptance through the single-cycle done pulse. A req_valid seen while busy has no effect on the bus sequence.
- R13: While busy is low, chip enable, write enable and output enable are high and the data pins are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_op | input | 2 | 0 byte write, 1 sector erase, 2 block erase, 3 chip erase |
| req_addr | input | ADDR_W | Target byte, sector or block address |
| req_data | input | DATA_W | Byte to write |
| poll_toggle | input | 1 | 0 selects bit 7 polling, 1 selects bit 6 toggle detection |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Valid with done: timeout or failed read-back |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_addr | output | ADDR_W | Flash address |
| fl_dq_out | output | DATA_W | Data driven toward the flash |
| fl_dq_oe | output | 1 | Drive enable for fl_dq_out |
| fl_dq_in | input | DATA_W | Data read from the flash |

## Verification
The assertions check the strobe discipline on every cycle: address stable across the falling write strobe, data held through its rise, no write and output enable overlap, bus released during reads, a quiet bus while idle, and the busy/done framing. The bench pairs the sequencer with a behavioural flash that reports busy for a chosen number of reads and can return a chosen number of corrupted bytes afterwards. Only those scenarios can show the exact command bytes, the polling end point in each mode, the recovery or failure decided by the two extra reads, and the timeout.

// File: rtl/flash_eng_pkg.sv
package flash_eng_pkg;

   typedef enum logic [1:0] {
      OP_PROG = 2'd0,
      OP_SECT = 2'd1,
      OP_BLK  = 2'd2,
      OP_CHIP = 2'd3
   } fl_op_e;

   typedef enum logic [2:0] {
      BP_IDLE, BP_SETUP, BP_STROBE, BP_HOLD, BP_READ, BP_GAP
   } bus_phase_e;

   typedef enum logic [2:0] {
      S_IDLE, S_WRITE, S_POLL, S_VERIFY, S_CONFIRM, S_FINISH
   } eng_state_e;

   localparam logic [15:0] CMD_ADDR_1 = 16'h5555;
   localparam logic [15:0] CMD_ADDR_2 = 16'h2AAA;

   localparam logic [7:0] CODE_KEY_1   = 8'hAA;
   localparam logic [7:0] CODE_KEY_2   = 8'h55;
   localparam logic [7:0] CODE_PROG    = 8'hA0;
   localparam logic [7:0] CODE_ERS_ARM = 8'h80;
   localparam logic [7:0] CODE_SECT    = 8'h30;
   localparam logic [7:0] CODE_BLK     = 8'h50;
   localparam logic [7:0] CODE_CHIP    = 8'h10;

   localparam int PROG_WRITES  = 4;
   localparam int ERASE_WRITES = 6;

endpackage

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
   import flash_eng_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 8
) (
   input  fl_op_e              op,
   input  logic [ADDR_W-1:0]   tgt_addr,
   input  logic [DATA_W-1:0]   tgt_data,
   input  logic [2:0]          idx,
   output logic [ADDR_W-1:0]   wr_addr,
   output logic [DATA_W-1:0]   wr_data,
   output logic                last
);

   localparam logic [ADDR_W-1:0] KEY_A1 = ADDR_W'(CMD_ADDR_1);
   localparam logic [ADDR_W-1:0] KEY_A2 = ADDR_W'(CMD_ADDR_2);
   localparam logic [2:0] PROG_LAST  = 3'(PROG_WRITES - 1);
   localparam logic [2:0] ERASE_LAST = 3'(ERASE_WRITES - 1);

   generate
      if (ADDR_W < 16) begin : g_bad_addr
         $error("flash_cmd_seq: ADDR_W must cover the command addresses");
      end
      if (DATA_W != 8) begin : g_bad_data
         $error("flash_cmd_seq: command codes are byte wide");
      end
   endgenerate

   always_comb begin
      wr_addr = KEY_A1;
      wr_data = DATA_W'(CODE_KEY_1);
      if (op == OP_PROG) begin
         case (idx)
            3'd0:    begin wr_addr = KEY_A1;   wr_data = DATA_W'(CODE_KEY_1); end
            3'd1:    begin wr_addr = KEY_A2;   wr_data = DATA_W'(CODE_KEY_2); end
            3'd2:    begin wr_addr = KEY_A1;   wr_data = DATA_W'(CODE_PROG);  end
            default: begin wr_addr = tgt_addr; wr_data = tgt_data;            end
         endcase
      end else begin
         case (idx)
            3'd0: begin wr_addr = KEY_A1; wr_data = DATA_W'(CODE_KEY_1);   end
            3'd1: begin wr_addr = KEY_A2; wr_data = DATA_W'(CODE_KEY_2);   end
            3'd2: begin wr_addr = KEY_A1; wr_data = DATA_W'(CODE_ERS_ARM); end
            3'd3: begin wr_addr = KEY_A1; wr_data = DATA_W'(CODE_KEY_1);   end
            3'd4: begin wr_addr = KEY_A2; wr_data = DATA_W'(CODE_KEY_2);   end
            default: begin
               case (op)
                  OP_SECT: begin wr_addr = tgt_addr; wr_data = DATA_W'(CODE_SECT); end
                  OP_BLK:  begin wr_addr = tgt_addr; wr_data = DATA_W'(CODE_BLK);  end
                  default: begin wr_addr = KEY_A1;   wr_data = DATA_W'(CODE_CHIP); end
               endcase
            end
         endcase
      end
   end

   assign last = (op == OP_PROG) ? (idx == PROG_LAST) : (idx == ERASE_LAST);

endmodule

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle
   import flash_eng_pkg::*;
#(
   parameter int ADDR_W     = 20,
   parameter int DATA_W     = 8,
   parameter int SETUP_CYC  = 1,
   parameter int STROBE_CYC = 3,
   parameter int HOLD_CYC   = 1,
   parameter int READ_CYC   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               is_read,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   output logic               cyc_done,
   output logic [DATA_W-1:0]  rdata,
   output logic               fl_ce_n,
   output logic               fl_we_n,
   output logic               fl_oe_n,
   output logic [ADDR_W-1:0]  fl_addr,
   output logic [DATA_W-1:0]  fl_dq_out,
   output logic               fl_dq_oe,
   input  logic [DATA_W-1:0]  fl_dq_in
);

   localparam int MAX_AB = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
   localparam int MAX_CD = (HOLD_CYC > READ_CYC) ? HOLD_CYC : READ_CYC;
   localparam int MAX_C  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
   localparam int CNT_W  = $clog2(MAX_C + 1);

   generate
      if (SETUP_CYC < 1 || STROBE_CYC < 1 || HOLD_CYC < 1 || READ_CYC < 1) begin : g_bad_len
         $error("flash_bus_cycle: every bus interval needs at least one cycle");
      end
   endgenerate

   bus_phase_e            ph_q;
   logic [CNT_W-1:0]      cnt_q;
   logic [CNT_W-1:0]      last_cnt;
   bus_phase_e            ph_next;
   logic [ADDR_W-1:0]     addr_q;
   logic [DATA_W-1:0]     data_q;

   always_comb begin
      case (ph_q)
         BP_SETUP:  begin last_cnt = CNT_W'(SETUP_CYC - 1);  ph_next = BP_STROBE; end
         BP_STROBE: begin last_cnt = CNT_W'(STROBE_CYC - 1); ph_next = BP_HOLD;   end
         BP_HOLD:   begin last_cnt = CNT_W'(HOLD_CYC - 1);   ph_next = BP_GAP;    end
         BP_READ:   begin last_cnt = CNT_W'(READ_CYC - 1);   ph_next = BP_GAP;    end
         default:   begin last_cnt = '0;                     ph_next = BP_IDLE;   end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= BP_IDLE;
         cnt_q  <= '0;
         addr_q <= '0;
         data_q <= '0;
         rdata  <= '0;
      end else begin
         case (ph_q)
            BP_IDLE: begin
               if (start) begin
                  addr_q <= addr;
                  data_q <= wdata;
                  cnt_q  <= '0;
                  ph_q   <= is_read ? BP_READ : BP_SETUP;
               end
            end
            BP_GAP: ph_q <= BP_IDLE;
            default: begin
               if (cnt_q == last_cnt) begin
                  cnt_q <= '0;
                  ph_q  <= ph_next;
                  if (ph_q == BP_READ) rdata <= fl_dq_in;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         endcase
      end
   end

   assign cyc_done  = (ph_q == BP_GAP);
   assign fl_ce_n   = (ph_q == BP_IDLE) || (ph_q == BP_GAP);
   assign fl_we_n   = (ph_q != BP_STROBE);
   assign fl_oe_n   = (ph_q != BP_READ);
   assign fl_dq_oe  = (ph_q == BP_SETUP) || (ph_q == BP_STROBE) || (ph_q == BP_HOLD);
   assign fl_addr   = addr_q;
   assign fl_dq_out = data_q;

endmodule

// File: rtl/flash_done_detect.sv
module flash_done_detect #(
   parameter bit TOGGLE_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic armed,
   input  logic sample,
   input  logic use_toggle,
   input  logic rd_msb,
   input  logic rd_b6,
   input  logic exp_msb,
   output logic status_ok
);

   logic poll_ok;
   assign poll_ok = (rd_msb == exp_msb);

   generate
      if (TOGGLE_EN) begin : g_toggle
         logic prev6_q;
         logic have_prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev6_q     <= 1'b0;
               have_prev_q <= 1'b0;
            end else if (!armed) begin
               have_prev_q <= 1'b0;
            end else if (sample) begin
               prev6_q     <= rd_b6;
               have_prev_q <= 1'b1;
            end
         end
         assign status_ok = use_toggle ? (have_prev_q && (rd_b6 == prev6_q)) : poll_ok;
      end else begin : g_poll_only
         logic unused_in;
         assign unused_in = ^{clk, rst_n, armed, sample, use_toggle, rd_b6};
         assign status_ok = poll_ok;
      end
   endgenerate

endmodule

// File: rtl/flash_timeout.sv
module flash_timeout #(
   parameter int LIMIT_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic [LIMIT_W-1:0] limit,
   output logic               expired
);

   logic [LIMIT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (!run)            cnt_q <= '0;
      else if (cnt_q != '1)     cnt_q <= cnt_q + 1'b1;
   end

   assign expired = run && (cnt_q >= limit);

endmodule

// File: rtl/flash_wr_engine.sv
module flash_wr_engine
   import flash_eng_pkg::*;
#(
   parameter int ADDR_W        = 20,
   parameter int DATA_W        = 8,
   parameter int SETUP_CYC     = 1,
   parameter int STROBE_CYC    = 3,
   parameter int HOLD_CYC      = 1,
   parameter int READ_CYC      = 2,
   parameter bit TOGGLE_EN     = 1'b1,
   parameter bit TIMEOUT_EN    = 1'b1,
   parameter int CLK_MHZ       = 125,
   parameter int PROG_LIMIT_US = 20,
   parameter int ERASE_SCALE   = 5000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [1:0]         req_op,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [DATA_W-1:0]  req_data,
   input  logic               poll_toggle,
   output logic               busy,
   output logic               done,
   output logic               error,
   output logic               fl_ce_n,
   output logic               fl_we_n,
   output logic               fl_oe_n,
   output logic [ADDR_W-1:0]  fl_addr,
   output logic [DATA_W-1:0]  fl_dq_out,
   output logic               fl_dq_oe,
   input  logic [DATA_W-1:0]  fl_dq_in
);

   localparam int TMO_PROG  = CLK_MHZ * PROG_LIMIT_US;
   localparam int TMO_ERASE = TMO_PROG * ERASE_SCALE;
   localparam int TMO_W     = $clog2(TMO_ERASE + 2);

   generate
      if (CLK_MHZ < 1 || PROG_LIMIT_US < 1 || ERASE_SCALE < 1) begin : g_bad_tmo
         $error("flash_wr_engine: timeout inputs must be positive");
      end
   endgenerate

   eng_state_e         st_q;
   fl_op_e             op_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [DATA_W-1:0]  data_q;
   logic               mode_q;
   logic [2:0]         idx_q;
   logic               issued_q;
   logic               conf_second_q;
   logic               conf_bad_q;
   logic               err_q;

   logic [ADDR_W-1:0]  seq_addr;
   logic [DATA_W-1:0]  seq_data;
   logic               seq_last;
   logic               bus_start;
   logic               bus_read;
   logic [ADDR_W-1:0]  bus_addr;
   logic               cyc_done;
   logic [DATA_W-1:0]  rd_data;
   logic [DATA_W-1:0]  exp_byte;
   logic               rd_match;
   logic               status_ok;
   logic               tmo_hit;

   flash_cmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_seq (
      .op       (op_q),
      .tgt_addr (addr_q),
      .tgt_data (data_q),
      .idx      (idx_q),
      .wr_addr  (seq_addr),
      .wr_data  (seq_data),
      .last     (seq_last)
   );

   assign bus_read  = (st_q == S_POLL) || (st_q == S_VERIFY) || (st_q == S_CONFIRM);
   assign bus_start = !issued_q && (bus_read || (st_q == S_WRITE));
   assign bus_addr  = (st_q == S_WRITE) ? seq_addr : addr_q;

   flash_bus_cycle #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETUP_CYC(SETUP_CYC),
      .STROBE_CYC(STROBE_CYC), .HOLD_CYC(HOLD_CYC), .READ_CYC(READ_CYC)
   ) i_bus (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (bus_start),
      .is_read   (bus_read),
      .addr      (bus_addr),
      .wdata     (seq_data),
      .cyc_done  (cyc_done),
      .rdata     (rd_data),
      .fl_ce_n   (fl_ce_n),
      .fl_we_n   (fl_we_n),
      .fl_oe_n   (fl_oe_n),
      .fl_addr   (fl_addr),
      .fl_dq_out (fl_dq_out),
      .fl_dq_oe  (fl_dq_oe),
      .fl_dq_in  (fl_dq_in)
   );

   assign exp_byte = (op_q == OP_PROG) ? data_q : '1;
   assign rd_match = (rd_data == exp_byte);

   flash_done_detect #(.TOGGLE_EN(TOGGLE_EN)) i_det (
      .clk        (clk),
      .rst_n      (rst_n),
      .armed      (st_q == S_POLL),
      .sample     ((st_q == S_POLL) && cyc_done),
      .use_toggle (mode_q),
      .rd_msb     (rd_data[DATA_W-1]),
      .rd_b6      (rd_data[6]),
      .exp_msb    (exp_byte[DATA_W-1]),
      .status_ok  (status_ok)
   );

   generate
      if (TIMEOUT_EN) begin : g_tmo
         logic [TMO_W-1:0] tmo_limit;
         assign tmo_limit = (op_q == OP_PROG) ? TMO_W'(TMO_PROG) : TMO_W'(TMO_ERASE);
         flash_timeout #(.LIMIT_W(TMO_W)) i_tmo (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (st_q == S_POLL),
            .limit   (tmo_limit),
            .expired (tmo_hit)
         );
      end else begin : g_no_tmo
         assign tmo_hit = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q          <= S_IDLE;
         op_q          <= OP_PROG;
         addr_q        <= '0;
         data_q        <= '0;
         mode_q        <= 1'b0;
         idx_q         <= '0;
         issued_q      <= 1'b0;
         conf_second_q <= 1'b0;
         conf_bad_q    <= 1'b0;
         err_q         <= 1'b0;
      end else begin
         if (bus_start)     issued_q <= 1'b1;
         else if (cyc_done) issued_q <= 1'b0;

         case (st_q)
            S_IDLE: begin
               if (req_valid) begin
                  op_q   <= fl_op_e'(req_op);
                  addr_q <= req_addr;
                  data_q <= req_data;
                  mode_q <= poll_toggle;
                  idx_q  <= '0;
                  err_q  <= 1'b0;
                  st_q   <= S_WRITE;
               end
            end
            S_WRITE: begin
               if (cyc_done) begin
                  if (seq_last) st_q  <= S_POLL;
                  else          idx_q <= idx_q + 1'b1;
               end
            end
            S_POLL: begin
               if (cyc_done) begin
                  if (status_ok) begin
                     st_q <= S_VERIFY;
                  end else if (tmo_hit) begin
                     err_q <= 1'b1;
                     st_q  <= S_FINISH;
                  end
               end
            end
            S_VERIFY: begin
               if (cyc_done) begin
                  if (rd_match) begin
                     st_q <= S_FINISH;
                  end else begin
                     conf_second_q <= 1'b0;
                     conf_bad_q    <= 1'b0;
                     st_q          <= S_CONFIRM;
                  end
               end
            end
            S_CONFIRM: begin
               if (cyc_done) begin
                  if (conf_second_q) begin
                     err_q <= conf_bad_q || !rd_match;
                     st_q  <= S_FINISH;
                  end else begin
                     conf_second_q <= 1'b1;
                     conf_bad_q    <= !rd_match;
                  end
               end
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign busy  = (st_q != S_IDLE);
   assign done  = (st_q == S_FINISH);
   assign error = done && err_q;

endmodule

// File: rtl/flash_wr_engine_chk.sv
module flash_wr_engine_chk #(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              busy,
   input logic              done,
   input logic              fl_ce_n,
   input logic              fl_we_n,
   input logic              fl_oe_n,
   input logic [ADDR_W-1:0] fl_addr,
   input logic [DATA_W-1:0] fl_dq_out,
   input logic              fl_dq_oe
);

   AST_NO_STROBE_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      !(!fl_we_n && !fl_oe_n)); // R5

   AST_ADDR_BEFORE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fl_we_n) |-> ($stable(fl_addr) && !fl_ce_n && fl_dq_oe)); // R5

   AST_DATA_HELD_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fl_we_n) |-> (fl_dq_oe && !fl_ce_n && $stable(fl_dq_out) && $stable(fl_addr))); // R5

   AST_READ_RELEASES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_oe_n |-> (!fl_dq_oe && !fl_ce_n)); // R6

   AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe)); // R13

   AST_ACCEPT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && req_valid) |=> busy); // R12

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R12

   AST_BUSY_ENDS_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(done)); // R12

endmodule

bind flash_wr_engine flash_wr_engine_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .busy      (busy),
   .done      (done),
   .fl_ce_n   (fl_ce_n),
   .fl_we_n   (fl_we_n),
   .fl_oe_n   (fl_oe_n),
   .fl_addr   (fl_addr),
   .fl_dq_out (fl_dq_out),
   .fl_dq_oe  (fl_dq_oe)
);

// File: tb/test_flash_wr_engine.sv
module test_flash_wr_engine;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_op = 2'd0;
   logic [19:0] req_addr = '0;
   logic [7:0]  req_data = '0;
   logic        poll_toggle = 1'b0;
   logic        busy, done, error;
   logic        fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe;
   logic [19:0] fl_addr;
   logic [7:0]  fl_dq_out;
   logic [7:0]  fl_dq_in = 8'h00;

   always #4 clk = ~clk;

   flash_wr_engine #(.CLK_MHZ(5), .PROG_LIMIT_US(20), .ERASE_SCALE(3)) i_flash_wr_engine (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_data(req_data), .poll_toggle(poll_toggle),
      .busy(busy), .done(done), .error(error),
      .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n),
      .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in)
   );

   int checks = 0;
   int errors = 0;

   // behavioural flash state
   int          mdl_busy = 0;
   int          mdl_bad = 0;
   bit          mdl_erase = 0;
   logic [7:0]  mdl_final = 8'hFF;
   int          wr_cnt = 0;
   int          rd_cnt = 0;
   int          exp_writes = 4;
   bit          early_read = 0;
   int          r5_viol = 0;
   int          r6_viol = 0;
   logic [19:0] wr_addr_log [0:7];
   logic [7:0]  wr_data_log [0:7];
   logic [19:0] addr_at_fall = '0;
   logic        prev_we = 1'b1;
   logic        prev_oe = 1'b1;

   function automatic logic [7:0] resp(input int n);
      logic [7:0] v;
      if (n <= mdl_busy) begin
         v = 8'h15;
         v[7] = mdl_erase ? 1'b0 : ~mdl_final[7];
         v[6] = n[0];
      end else if (n <= mdl_busy + mdl_bad) begin
         v = mdl_final ^ 8'h01;
      end else begin
         v = mdl_final;
      end
      return v;
   endfunction

   function automatic logic [27:0] exp_wr(input int op, input logic [19:0] a,
                                          input logic [7:0] d, input int i);
      if (op == 0) begin
         case (i)
            0: return {20'h05555, 8'hAA};
            1: return {20'h02AAA, 8'h55};
            2: return {20'h05555, 8'hA0};
            default: return {a, d};
         endcase
      end
      case (i)
         0: return {20'h05555, 8'hAA};
         1: return {20'h02AAA, 8'h55};
         2: return {20'h05555, 8'h80};
         3: return {20'h05555, 8'hAA};
         4: return {20'h02AAA, 8'h55};
         default: begin
            if (op == 1) return {a, 8'h30};
            if (op == 2) return {a, 8'h50};
            return {20'h05555, 8'h10};
         end
      endcase
   endfunction

   // expected number of reads and result from R7, R8 and R9
   function automatic void walk(input bit tog, output int reads, output bit err);
      int  phase = 0;
      bit  have = 0;
      bit  p6 = 0;
      bit  bad = 0;
      int  c = 0;
      reads = 0;
      err = 1'b1;
      for (int n = 1; n < 1000; n++) begin
         logic [7:0] v;
         v = resp(n);
         if (phase == 0) begin
            bit pass;
            if (tog) pass = have && (v[6] == p6);
            else     pass = (v[7] == mdl_final[7]);
            p6 = v[6];
            have = 1;
            if (pass) phase = 1;
         end else if (phase == 1) begin
            if (v == mdl_final) begin reads = n; err = 1'b0; return; end
            phase = 2;
         end else begin
            bad = bad | (v != mdl_final);
            c++;
            if (c == 2) begin reads = n; err = bad; return; end
         end
      end
   endfunction

   always @(negedge clk) begin
      if (prev_we && !fl_we_n) addr_at_fall = fl_addr;
      if (!prev_we && fl_we_n) begin
         if (!fl_dq_oe || fl_addr != addr_at_fall) r5_viol++;
         if (wr_cnt < 8) begin
            wr_addr_log[wr_cnt] = fl_addr;
            wr_data_log[wr_cnt] = fl_dq_out;
         end
         wr_cnt++;
      end
      if (prev_oe && !fl_oe_n) begin
         if (fl_dq_oe || fl_ce_n) r6_viol++;
         if (wr_cnt < exp_writes) early_read = 1;
         rd_cnt++;
         fl_dq_in = resp(rd_cnt);
      end
      prev_we = fl_we_n;
      prev_oe = fl_oe_n;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic run_op(input int op, input logic [19:0] a, input logic [7:0] d,
                         input bit tog, input int nbusy, input int nbad, input bit want_tmo);
      int  exp_reads;
      bit  exp_err;
      int  waited = 0;
      string seq_req;
      seq_req = (op == 0) ? "R1" : (op == 1) ? "R2" : (op == 2) ? "R3" : "R4";
      mdl_busy   = nbusy;
      mdl_bad    = nbad;
      mdl_erase  = (op != 0);
      mdl_final  = (op == 0) ? d : 8'hFF;
      exp_writes = (op == 0) ? 4 : 6;
      wr_cnt = 0; rd_cnt = 0; early_read = 0; r5_viol = 0; r6_viol = 0;
      @(negedge clk);
      req_valid = 1'b1; req_op = 2'(op); req_addr = a; req_data = d; poll_toggle = tog;
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy == 1'b1, "R12", "busy after accept", busy, 1);
      repeat (3) @(negedge clk);
      // request while busy must not alter the sequence (R12)
      req_valid = 1'b1; req_op = 2'(3 - op); req_addr = ~a; req_data = ~d;
      @(negedge clk);
      req_valid = 1'b0;
      while (!done && waited < 5000) begin
         @(negedge clk);
         waited++;
      end
      chk(done == 1'b1, "R12", "done seen", done, 1);
      walk(tog, exp_reads, exp_err);
      chk(wr_cnt == exp_writes, seq_req, "write count", wr_cnt, exp_writes);
      for (int i = 0; i < exp_writes && i < 8; i++) begin
         logic [27:0] e;
         e = exp_wr(op, a, d, i);
         chk({wr_addr_log[i], wr_data_log[i]} == e, seq_req, "write cycle",
             {wr_addr_log[i], wr_data_log[i]}, e);
      end
      chk(!early_read, "R10", "read before last write", early_read, 0);
      chk(r5_viol == 0, "R5", "strobe violations", r5_viol, 0);
      chk(r6_viol == 0, "R6", "read cycle violations", r6_viol, 0);
      if (want_tmo) begin
         chk(error == 1'b1, "R11", "timeout error", error, 1);
      end else begin
         chk(rd_cnt == exp_reads, tog ? "R8" : "R7", "read count", rd_cnt, exp_reads);
         chk(error == exp_err, "R9", "error flag", error, exp_err);
      end
      @(negedge clk);
      chk(busy == 1'b0 && done == 1'b0, "R12", "idle after done", {busy, done}, 0);
      chk(fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe, "R13", "idle bus",
          {fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe}, 4'b1110);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      chk(busy == 1'b0 && done == 1'b0, "R12", "reset outputs", {busy, done}, 0);
      chk(fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe, "R13", "reset bus",
          {fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe}, 4'b1110);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      run_op(0, 20'h12345, 8'h5A, 1'b0, 3, 0, 1'b0);   // R1 R7 plain
      run_op(1, 20'hAB000, 8'h00, 1'b0, 4, 0, 1'b0);   // R2
      run_op(2, 20'h30000, 8'h00, 1'b1, 5, 0, 1'b0);   // R3 R8
      run_op(3, 20'h00000, 8'h00, 1'b1, 2, 0, 1'b0);   // R4 R8
      run_op(0, 20'hFFFFF, 8'hC3, 1'b0, 2, 2, 1'b0);   // R9 recovered by re-reads
      run_op(0, 20'h00F0F, 8'h81, 1'b1, 3, 2, 1'b0);   // R9 toggle, recovered
      run_op(1, 20'h44000, 8'h00, 1'b0, 2, 3, 1'b0);   // R9 rejection stands
      run_op(0, 20'h0ABCD, 8'h7E, 1'b0, 60, 0, 1'b1);  // R11 program bound
      run_op(1, 20'h51000, 8'h00, 1'b1, 120, 0, 1'b1); // R11 erase bound

      for (int t = 0; t < 10; t++) begin
         int op  = int'($urandom_range(0, 3));
         int nb  = int'($urandom_range(2, 8));
         int nk  = int'($urandom_range(0, 3));
         logic [19:0] a = 20'($urandom);
         logic [7:0]  d = 8'($urandom);
         bit tg = 1'($urandom);
         run_op(op, a, d, tg, nb, nk, 1'b0);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule